// File: doc/BRIEF.md
# Common-Mode Offset Pivoting Solver

This block finishes one part of a modulation-layer allocation problem for a three-phase cascaded bridge converter. An upstream allocator has already sorted the decision variables of each phase by falling benefit. It has filled each list with feasible starting values and picked one "basic" (unsaturated) variable per phase. The block then improves the objective by moving a shared offset. The same amount is added to, or taken from, the three basic variables, so every phase-to-phase difference stays the same and every external constraint still holds.

It works one pivot per clock cycle. It adds the three basic benefits to choose a direction. It finds how much room each basic variable has in that direction and moves all three by the smallest room. Each phase whose basic variable hit its bound hands the basic role to its neighbour in benefit order. The run ends when the benefit sum reaches zero or reverses sign, when a phase runs off the end of its list, or when the iteration ceiling of 6N-3 is reached. The block returns the final variable values, a done flag, an error flag and the number of pivots applied.

Top module: `cmopt_shift_opt`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low, `iters_o` is 0 and `val_o` is all zero.
- R2: If the three starting basic benefits sum to exactly zero, the run ends with no pivot, `iters_o` = 0, and every value equals its start value.
- R3: If the sum of the basic benefits is positive, each of the three basic values rises by the same amount. That amount is the smallest upper headroom (hi − value) among the three.
- R4: If the sum is negative, each basic value falls by the smallest lower headroom (value − lo) among the three.
- R5: Every phase whose headroom equals the applied amount passes the basic role on. When rising it passes to the next index (lower benefit); when falling it passes to the previous index. Ties move several phases at once, and a zero amount still moves the pointer.
- R6: The run stops without a further pivot as soon as the basic benefit sum is zero or has the opposite sign to the direction of the first pivot.
- R7: The run stops right after a pivot that saturates a basic variable sitting at index N−1 while rising, or at index 0 while falling.
- R8: Throughout a run, the differences between the phase sums of the values (phase0−phase1 and phase1−phase2) do not change.
- R9: `iters_o` never exceeds 6N−3. `err_o` is set only when the count reaches that bound with no other stop condition, and on the lists used here it stays low.
- R10: `busy_o` is high while pivoting and `done_o` is high after the run until the next start. The two are never high together.
- R11: Variables that never become basic keep their start values.

Packing: the entry for phase k and index j sits at slice ((k·N)+j)·W; index 0 holds the highest benefit; the values are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loads the lists and begins a run (ignored while busy) |
| ben_i | input | 3*N*BW | Benefits, sorted in falling order per phase |
| init_i | input | 3*N*VW | Feasible start values |
| lo_i | input | 3*N*VW | Lower bounds |
| hi_i | input | 3*N*VW | Upper bounds |
| ptr_i | input | 3*PW | Starting basic index of each phase |
| val_o | output | 3*N*VW | Current and final values |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete |
| err_o | output | 1 | Iteration ceiling reached |
| iters_o | output | CW | Number of pivots applied |

## Verification
The bench targets a zero starting sum, a sign flip after a single pivot, running off the end of a list in each direction, two phases tied on headroom, and a basic variable that already sits on its bound. A design that moved the offset on a zero sum, or did not stop at the flip, would change values that should stay put. One that moved only a single tied pointer, or skipped a zero-amount pivot, would give a different pivot count and different final values. Indexing the neighbour the wrong way or missing exhaustion would saturate the wrong variables. A reference solver in the bench predicts every case, including about forty generated ones.

// File: rtl/cmopt_pkg.sv
package cmopt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cm_state_t;
endpackage

// File: rtl/cmopt_pick.sv
// Selects the basic entry of one phase from its flattened lists.
module cmopt_pick #(
  parameter int N  = 4,
  parameter int VW = 16,
  parameter int BW = 16,
  parameter int PW = 2
) (
  input  logic [PW-1:0]   ptr_i,
  input  logic [N*BW-1:0] ben_i,
  input  logic [N*VW-1:0] val_i,
  input  logic [N*VW-1:0] lo_i,
  input  logic [N*VW-1:0] hi_i,
  output logic [BW-1:0]   b_o,
  output logic [VW-1:0]   x_o,
  output logic [VW-1:0]   lo_o,
  output logic [VW-1:0]   hi_o
);
  always_comb begin
    b_o  = ben_i[int'(ptr_i)*BW +: BW];
    x_o  = val_i[int'(ptr_i)*VW +: VW];
    lo_o = lo_i[int'(ptr_i)*VW +: VW];
    hi_o = hi_i[int'(ptr_i)*VW +: VW];
  end
endmodule

// File: rtl/cmopt_step.sv
// Direction, headroom and step amount for one pivot.
module cmopt_step #(
  parameter int VW = 16,
  parameter int BW = 16,
  localparam int SW = BW + 2
) (
  input  logic [BW-1:0] b_i  [3],
  input  logic [VW-1:0] x_i  [3],
  input  logic [VW-1:0] lo_i [3],
  input  logic [VW-1:0] hi_i [3],
  output logic          up_o,
  output logic          zero_o,
  output logic [VW:0]   amt_o,
  output logic [2:0]    sat_o
);
  logic signed [SW-1:0] sum;
  logic [VW:0]          room [3];

  function automatic logic [VW:0] headroom(input logic up,
                                           input logic [VW-1:0] x,
                                           input logic [VW-1:0] lo,
                                           input logic [VW-1:0] hi);
    logic signed [VW:0] xe, le, he, d;
    xe = $signed({x[VW-1], x});
    le = $signed({lo[VW-1], lo});
    he = $signed({hi[VW-1], hi});
    d  = up ? (he - xe) : (xe - le);
    return d;
  endfunction

  function automatic logic [VW:0] min3(input logic [VW:0] a,
                                       input logic [VW:0] b,
                                       input logic [VW:0] c);
    logic [VW:0] m;
    m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  always_comb begin
    sum = SW'($signed(b_i[0])) + SW'($signed(b_i[1])) + SW'($signed(b_i[2]));
    up_o   = (sum > 0);
    zero_o = (sum == '0);
    for (int k = 0; k < 3; k++) room[k] = headroom(up_o, x_i[k], lo_i[k], hi_i[k]);
    amt_o = min3(room[0], room[1], room[2]);
    for (int k = 0; k < 3; k++) sat_o[k] = (room[k] == amt_o);
  end
endmodule

// File: rtl/cmopt_ctrl.sv
// Run sequencing and the pivot counter.
module cmopt_ctrl
  import cmopt_pkg::*;
#(
  parameter int MAXIT = 21,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          exhaust_i,
  output logic          load_o,
  output logic          apply_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] cnt_o
);
  cm_state_t st_q;

  assign load_o  = start_i && (st_q != ST_RUN);
  assign apply_o = (st_q == ST_RUN) && !stop_i;
  assign busy_o  = (st_q == ST_RUN);
  assign done_o  = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (load_o) begin
      st_q  <= ST_RUN;
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (st_q == ST_RUN) begin
      if (stop_i) begin
        st_q <= ST_FIN;
      end else begin
        cnt_o <= cnt_o + 1'b1;
        if (exhaust_i) begin
          st_q <= ST_FIN;
        end else if (cnt_o == CW'(MAXIT - 1)) begin
          st_q  <= ST_FIN;
          err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmopt_shift_opt.sv
module cmopt_shift_opt #(
  parameter int N  = 4,
  parameter int VW = 16,
  parameter int BW = 16,
  localparam int PW    = (N > 1) ? $clog2(N) : 1,
  localparam int MAXIT = 6 * N - 3,
  localparam int CW    = $clog2(MAXIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3*N*BW-1:0] ben_i,
  input  logic [3*N*VW-1:0] init_i,
  input  logic [3*N*VW-1:0] lo_i,
  input  logic [3*N*VW-1:0] hi_i,
  input  logic [3*PW-1:0]   ptr_i,
  output logic [3*N*VW-1:0] val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CW-1:0]     iters_o
);
  localparam int PV = N * VW;
  localparam int PB = N * BW;

  logic [3*PV-1:0] val_q, lo_q, hi_q;
  logic [3*PB-1:0] ben_q;
  logic [3*PW-1:0] ptr_q;
  logic            dir_up_q;

  // named internal events
  logic [BW-1:0] bas_b  [3];
  logic [VW-1:0] bas_x  [3];
  logic [VW-1:0] bas_lo [3];
  logic [VW-1:0] bas_hi [3];
  logic [VW-1:0] bas_nx [3];
  logic          step_up, sum_zero, first_step, stop_sign, exhaust;
  logic          load, apply;
  logic [VW:0]   step_amt;
  logic [2:0]    sat_mask, at_end;

  function automatic logic [VW-1:0] shift_val(input logic [VW-1:0] x,
                                              input logic [VW:0] amt,
                                              input logic up);
    logic signed [VW:0] t;
    t = up ? ($signed({x[VW-1], x}) + $signed(amt))
           : ($signed({x[VW-1], x}) - $signed(amt));
    return t[VW-1:0];
  endfunction

  for (genvar k = 0; k < 3; k++) begin : g_phase
    logic [PW-1:0] p;
    assign p = ptr_q[k*PW +: PW];
    cmopt_pick #(.N(N), .VW(VW), .BW(BW), .PW(PW)) u_pick (
      .ptr_i (p),
      .ben_i (ben_q[k*PB +: PB]),
      .val_i (val_q[k*PV +: PV]),
      .lo_i  (lo_q[k*PV +: PV]),
      .hi_i  (hi_q[k*PV +: PV]),
      .b_o   (bas_b[k]),
      .x_o   (bas_x[k]),
      .lo_o  (bas_lo[k]),
      .hi_o  (bas_hi[k])
    );
    assign at_end[k] = step_up ? (p == PW'(N - 1)) : (p == '0);
    assign bas_nx[k] = shift_val(bas_x[k], step_amt, step_up);
  end

  cmopt_step #(.VW(VW), .BW(BW)) u_step (
    .b_i   (bas_b),
    .x_i   (bas_x),
    .lo_i  (bas_lo),
    .hi_i  (bas_hi),
    .up_o  (step_up),
    .zero_o(sum_zero),
    .amt_o (step_amt),
    .sat_o (sat_mask)
  );

  assign first_step = (iters_o == '0);
  assign stop_sign  = sum_zero || (!first_step && (step_up != dir_up_q));
  assign exhaust    = |(sat_mask & at_end);

  cmopt_ctrl #(.MAXIT(MAXIT), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_sign),
    .exhaust_i(exhaust),
    .load_o   (load),
    .apply_o  (apply),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .cnt_o    (iters_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      ben_q    <= '0;
      ptr_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (load) begin
      val_q    <= init_i;
      lo_q     <= lo_i;
      hi_q     <= hi_i;
      ben_q    <= ben_i;
      ptr_q    <= ptr_i;
      dir_up_q <= 1'b0;
    end else if (apply) begin
      dir_up_q <= step_up;
      for (int k = 0; k < 3; k++) begin
        val_q[(k*N + int'(ptr_q[k*PW +: PW]))*VW +: VW] <= bas_nx[k];
        if (sat_mask[k] && !at_end[k]) begin
          ptr_q[k*PW +: PW] <= step_up ? (ptr_q[k*PW +: PW] + 1'b1)
                                       : (ptr_q[k*PW +: PW] - 1'b1);
        end
      end
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/cmopt_shift_chk.sv
module cmopt_shift_chk #(
  parameter int N     = 4,
  parameter int VW    = 16,
  parameter int MAXIT = 21,
  parameter int CW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*N*VW-1:0] val,
  input logic [3*N*VW-1:0] lo,
  input logic [3*N*VW-1:0] hi,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [CW-1:0]     iters
);
  localparam int SW = VW + 8;
  logic signed [SW-1:0] psum [3];
  logic signed [SW-1:0] d01, d12;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      psum[k] = '0;
      for (int j = 0; j < N; j++)
        psum[k] = psum[k] + SW'($signed(val[(k*N + j)*VW +: VW]));
    end
    d01 = psum[0] - psum[1];
    d12 = psum[1] - psum[2];
  end

  // R8: an equal shift of the three basics keeps phase differences
  a_r8_diff_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(d01) && $stable(d12)));

  // R9: counter ceiling
  a_r9_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iters <= CW'(MAXIT));

  // R9: error only as a way of finishing
  a_r9_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10: busy and done exclusive
  a_r10_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10: one pivot per cycle at most
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((iters == $past(iters)) || (iters == $past(iters) + 1'b1)));

  // R3 / R4: every value stays inside its bounds while pivoting
  for (genvar e = 0; e < 3*N; e++) begin : g_bnd
    a_r3_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (($signed(val[e*VW +: VW]) >= $signed(lo[e*VW +: VW])) &&
                ($signed(val[e*VW +: VW]) <= $signed(hi[e*VW +: VW]))));
  end
endmodule

bind cmopt_shift_opt cmopt_shift_chk #(.N(N), .VW(VW), .MAXIT(MAXIT), .CW(CW)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .val  (val_q),
  .lo   (lo_q),
  .hi   (hi_q),
  .busy (busy_o),
  .done (done_o),
  .err  (err_o),
  .iters(iters_o)
);

// File: tb/sim_cmopt_shift_opt.sv
`timescale 1ns/1ps
module sim_cmopt_shift_opt;
  localparam int N = 4, VW = 16, BW = 16, PW = 2, CW = 5, MAXIT = 6*N-3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start;
  logic [3*N*BW-1:0] ben;
  logic [3*N*VW-1:0] init, lo_v, hi_v, val;
  logic [3*PW-1:0] ptr;
  logic busy, done, err;
  logic [CW-1:0] iters;

  cmopt_shift_opt #(.N(N), .VW(VW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ben_i(ben), .init_i(init),
    .lo_i(lo_v), .hi_i(hi_v), .ptr_i(ptr), .val_o(val), .busy_o(busy),
    .done_o(done), .err_o(err), .iters_o(iters));

  int b[3][N], x[3][N], lo[3][N], hi[3][N], p[3];
  int qv[$];
  string qt[$];
  int n_chk = 0, n_bad = 0, seed = 7, wd = 0;
  bit prev_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32767;
  endfunction

  task automatic set_phase(input int k, input int pp, input int b0, input int b1,
                           input int b2, input int b3, input int l, input int h, input int xb);
    b[k][0] = b0; b[k][1] = b1; b[k][2] = b2; b[k][3] = b3;
    p[k] = pp;
    for (int j = 0; j < N; j++) begin
      lo[k][j] = l; hi[k][j] = h;
      x[k][j] = (j < pp) ? h : (j > pp) ? l : xb;
    end
  endtask

  task automatic gen_case();
    for (int k = 0; k < 3; k++) begin
      int bv, l, h;
      bv = 60 - rnd() % 90;
      p[k] = rnd() % N;
      for (int j = 0; j < N; j++) begin
        b[k][j] = bv;
        bv = bv - rnd() % 25;
        l = -(5 + rnd() % 40);
        h = 5 + rnd() % 40;
        lo[k][j] = l; hi[k][j] = h;
        x[k][j] = (j < p[k]) ? h : (j > p[k]) ? l : l + rnd() % (h - l + 1);
      end
    end
  endtask

  // reference solver and scoreboard push
  task automatic drive(input string tag);
    int mx[3][N], mp[3], it, er, dir, s, amt, hr[3], up;
    bit stop;
    mx = x; mp = p; it = 0; er = 0; dir = 0;
    forever begin
      s = b[0][mp[0]] + b[1][mp[1]] + b[2][mp[2]];
      if (s == 0) break;
      up = (s > 0) ? 1 : -1;
      if (dir != 0 && up != dir) break;
      dir = up;
      for (int k = 0; k < 3; k++)
        hr[k] = (up > 0) ? hi[k][mp[k]] - mx[k][mp[k]] : mx[k][mp[k]] - lo[k][mp[k]];
      amt = hr[0];
      if (hr[1] < amt) amt = hr[1];
      if (hr[2] < amt) amt = hr[2];
      stop = 0;
      for (int k = 0; k < 3; k++) begin
        mx[k][mp[k]] += up * amt;
        if (hr[k] == amt) begin
          if (up > 0 && mp[k] == N-1) stop = 1;
          else if (up < 0 && mp[k] == 0) stop = 1;
          else mp[k] += up;
        end
      end
      it++;
      if (stop) break;
      if (it == MAXIT) begin er = 1; break; end
    end
    qt.push_back(tag);
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < N; j++) begin
        qv.push_back(mx[k][j]); qv.push_back(x[k][j]);
      end
    qv.push_back(it); qv.push_back(er);
    for (int k = 0; k < 3; k++) begin
      int ps;
      ps = 0;
      for (int j = 0; j < N; j++) ps += x[k][j];
      qv.push_back(ps);
    end
    for (int k = 0; k < 3; k++) begin
      ptr[k*PW +: PW] = PW'(p[k]);
      for (int j = 0; j < N; j++) begin
        ben[(k*N+j)*BW +: BW]  = b[k][j][BW-1:0];
        init[(k*N+j)*VW +: VW] = x[k][j][VW-1:0];
        lo_v[(k*N+j)*VW +: VW] = lo[k][j][VW-1:0];
        hi_v[(k*N+j)*VW +: VW] = hi[k][j][VW-1:0];
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      string tag;
      int e, i0, a, ps[3], ip[3];
      if (qt.size() == 0) chk(0, "R10", 1, 0);
      else begin
        tag = qt.pop_front();
        for (int k = 0; k < 3; k++) begin
          ps[k] = 0;
          for (int j = 0; j < N; j++) begin
            e = qv.pop_front(); i0 = qv.pop_front();
            a = int'($signed(val[(k*N+j)*VW +: VW]));
            ps[k] += a;
            chk(a == e, (e == i0) ? {tag, " R11"} : tag, a, e);
          end
        end
        e = qv.pop_front(); chk(int'(iters) == e, {tag, " iters"}, int'(iters), e);
        e = qv.pop_front(); chk(int'(err) == e, "R9 err", int'(err), e);
        chk(int'(iters) <= MAXIT, "R9 bound", int'(iters), MAXIT);
        for (int k = 0; k < 3; k++) ip[k] = qv.pop_front();
        chk(ps[0]-ps[1] == ip[0]-ip[1], "R8 d01", ps[0]-ps[1], ip[0]-ip[1]);
        chk(ps[1]-ps[2] == ip[1]-ip[2], "R8 d12", ps[1]-ps[2], ip[1]-ip[2]);
        chk(!busy, "R10 busy with done", int'(busy), 0);
      end
    end
    prev_done = done;
  end

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      chk(0, "watchdog", wd, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ben = '0; init = '0; lo_v = '0; hi_v = '0; ptr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
    chk(iters == '0, "R1 iters", int'(iters), 0);
    chk(val == '0, "R1 values", int'(val != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R1 after release", int'({busy, done}), 0);

    // R2: zero sum at start
    set_phase(0, 1, 9, 4, 1, 0, -20, 20, 3);
    set_phase(1, 2, 8, 6, -1, -5, -20, 20, -4);
    set_phase(2, 0, -3, -7, -9, -12, -20, 20, 11);
    drive("R2");

    // R6: one upward pivot, then the sum flips
    set_phase(0, 0, 5, -20, -30, -40, -10, 10, 8);
    set_phase(1, 1, 9, 3, 1, 0, -10, 10, 0);
    set_phase(2, 2, 7, 4, 2, 1, -10, 10, -5);
    drive("R6 R3");

    // R7: upward exhaustion at last index
    set_phase(0, 3, 50, 40, 30, 20, -10, 10, 5);
    set_phase(1, 0, 10, 9, 8, 7, -30, 30, 0);
    set_phase(2, 0, 10, 9, 8, 7, -30, 30, 0);
    drive("R7 R3");

    // R7: downward exhaustion at index 0
    set_phase(0, 0, -20, -30, -40, -50, -10, 10, -6);
    set_phase(1, 2, -1, -5, -9, -13, -30, 30, 10);
    set_phase(2, 3, -2, -4, -8, -16, -30, 30, 12);
    drive("R7 R4");

    // R5: tie on headroom moves two pointers
    set_phase(0, 1, 9, 8, 7, 6, -10, 10, 4);
    set_phase(1, 1, 5, 4, 3, 2, -10, 10, 4);
    set_phase(2, 1, 3, 2, 1, 0, -10, 10, 0);
    drive("R5 R3");

    // R5: zero headroom still passes the basic role on
    set_phase(0, 0, 20, 15, -40, -50, -10, 10, 10);
    set_phase(1, 1, 9, 6, 2, 1, -10, 10, 2);
    set_phase(2, 2, 9, 7, 3, -2, -10, 10, -1);
    drive("R5 R3");

    // R4: downward run through several pivots
    set_phase(0, 2, 40, 5, -6, -8, -15, 15, 3);
    set_phase(1, 2, 30, 4, -5, -9, -15, 15, -2);
    set_phase(2, 1, 20, -4, -7, -9, -15, 15, 6);
    drive("R4 R5");

    for (int c = 0; c < 40; c++) begin
      gen_case();
      drive("R3 R4 R5 R6 R7");
    end

    repeat (4) @(negedge clk);
    chk(qt.size() == 0, "R10 pending results", qt.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule